// File: doc/BRIEF.md
# Pipeline Exception Prioritizer

This block sits beside the control path of a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each cycle it collects the synchronous fault flags from the stages that can raise them, together with each stage's valid bit and instruction address. It also keeps an asynchronous service request (device I/O or a hardware malfunction report, already synchronised to the clock). It then chooses a single winning event. Several faults can appear in the same cycle. The winner is always the one belonging to the oldest instruction, which is the deepest stage, and not the one with the most urgent cause.

In the cycle of the decision, and without a register stage on the way, the block pulses write enables for a cause register and an exception-PC register and presents their values. It asserts a flush for the offending stage and for every younger stage, and overrides the next-PC mux with a fixed handler address. Older instructions carry on and complete. A memory-write request from the memory stage is suppressed when that stage is flushed, so the flushed instruction changes no memory state.

An asynchronous request is remembered in a pending flag. It is taken only at an instruction boundary: just before the instruction in decode, or just before the one in fetch when decode holds a bubble. The instructions ahead of that boundary are left to finish.

Top module: `trap_sequencer`

## Requirements
- R1: After reset, with no fault flags and no request, `cause_we`, `epc_we` and `pc_override` are 0, `flush_vec` is all zero, `pc_target` is 0 and no request is pending.
- R2: A single fault on a valid stage asserts `cause_we` and `epc_we` in the same cycle. `epc_val` carries that stage's address. `cause_val` carries its code: 4 for a fetch page fault (fetch stage), 10 for an undefined opcode (decode stage), 12 for an arithmetic overflow (execute stage) and 5 for a data page fault (memory stage).
- R3: When faults are present in several valid stages in one cycle, the deepest stage wins. Depth order is memory > execute > decode > fetch. `epc_val` and `cause_val` follow the winner.
- R4: `flush_vec` has bit 0 = fetch, 1 = decode, 2 = execute, 3 = memory and 4 = writeback. When an event is taken, the bit of the winning stage and every bit below it are 1, and every bit above it is 0.
- R5: When an event is taken, `pc_override` is 1 and `pc_target` is 0x80000180. With no event, `pc_override` is 0 and `pc_target` is 0.
- R6: A fault flag on a stage whose `stg_valid` bit is 0 is ignored.
- R7: A one-cycle pulse on `dev_irq` sets a pending flag at the next clock edge. From the following cycle it is taken with cause 0, attributed to the decode-stage instruction: `epc_val` is the decode address and `flush_vec` is 5'b00011.
- R8: A pending request waits while the execute or memory stage holds a valid fault. It also waits while both the decode and fetch stages are empty. It is taken in the first cycle in which neither holds.
- R9: At the same boundary a pending request beats the fault of the instruction it precedes. It beats an undefined opcode in decode. When decode is empty and fetch is valid, it is taken at the fetch address ahead of a fetch page fault, with `flush_vec` 5'b00001.
- R10: `mem_we_out` equals `mem_we_in` except in a cycle in which the memory stage is flushed, when it is 0.
- R11: A taken request is cleared from the pending flag, so it is not taken a second time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stg_valid | input | 4 | Valid bits, bit 0 fetch to bit 3 memory |
| stg_pc_flat | input | 128 | Stage addresses, fetch in bits 31:0, memory in bits 127:96 |
| fetch_fault | input | 1 | Page fault on instruction fetch |
| undef_op | input | 1 | Undefined opcode in decode |
| alu_ovf | input | 1 | Arithmetic overflow in execute |
| data_fault | input | 1 | Page fault on data access |
| dev_irq | input | 1 | Asynchronous service request pulse |
| mem_we_in | input | 1 | Memory-write request of the memory stage |
| cause_we | output | 1 | Cause register write enable |
| cause_val | output | 5 | Cause code to write |
| epc_we | output | 1 | Exception-PC register write enable |
| epc_val | output | 32 | Address of the offending instruction |
| flush_vec | output | 5 | Per-stage flush, bit 0 fetch |
| pc_override | output | 1 | Select handler address as next PC |
| pc_target | output | 32 | Handler address when overriding |
| mem_we_out | output | 1 | Gated memory-write request |

## Verification
A broken age comparison would show in the same cycle as a wrong `epc_val`, a wrong `cause_val` and a flush mask whose edge sits at the wrong bit. Injecting faults in all four stages at once shows whether the memory-stage address is the one recorded. A wrong pending flag shows one cycle after a request pulse. A lost flag gives no write enable at the boundary. A flag that does not clear gives a second take in the cycle after the first. A stuck or missing memory-write gate shows directly on `mem_we_out` in the cycle of a memory-stage fault.

// File: rtl/trap_pkg.sv
package trap_pkg;
   // stage indices; depth order is behaviour (higher index = older instruction)
   localparam int STG_IF  = 0;
   localparam int STG_ID  = 1;
   localparam int STG_EX  = 2;
   localparam int STG_MEM = 3;
   localparam int STG_WB  = 4;
   // stages that can raise a synchronous fault
   localparam int N_TRAP_STG = STG_MEM + 1;
   localparam int CODE_W = 5;

   typedef enum logic [CODE_W-1:0] {
      CC_INTR   = 5'd0,
      CC_IFAULT = 5'd4,
      CC_DFAULT = 5'd5,
      CC_UNDEF  = 5'd10,
      CC_OVF    = 5'd12
   } cause_e;
endpackage

// File: rtl/trap_src_map.sv
module trap_src_map
   import trap_pkg::*;
#(
   parameter int  NT           = N_TRAP_STG,
   parameter bit  IRQ_AT_FETCH = 1'b1
) (
   input  logic [NT-1:0]             valid,
   input  logic                      fetch_fault,
   input  logic                      undef_op,
   input  logic                      alu_ovf,
   input  logic                      data_fault,
   input  logic                      irq_pend,
   output logic [NT-1:0]             ev,
   output logic [NT-1:0]             irq_slot,
   output logic [NT-1:0][CODE_W-1:0] code
);
   logic irq_fetch_ok;

   generate
      if (IRQ_AT_FETCH) begin : g_fetch_slot
         assign irq_fetch_ok = irq_pend & ~valid[STG_ID];
      end else begin : g_no_fetch_slot
         assign irq_fetch_ok = 1'b0;
      end
   endgenerate

   always_comb begin
      ev       = '0;
      irq_slot = '0;
      code     = '0;
      // fetch slot: request ahead of the fetched instruction
      if (valid[STG_IF]) begin
         if (irq_fetch_ok) begin
            ev[STG_IF]       = 1'b1;
            irq_slot[STG_IF] = 1'b1;
            code[STG_IF]     = CC_INTR;
         end else if (fetch_fault) begin
            ev[STG_IF]   = 1'b1;
            code[STG_IF] = CC_IFAULT;
         end
      end
      // decode slot: request ahead of the decoded instruction
      if (valid[STG_ID]) begin
         if (irq_pend) begin
            ev[STG_ID]       = 1'b1;
            irq_slot[STG_ID] = 1'b1;
            code[STG_ID]     = CC_INTR;
         end else if (undef_op) begin
            ev[STG_ID]   = 1'b1;
            code[STG_ID] = CC_UNDEF;
         end
      end
      if (valid[STG_EX] && alu_ovf) begin
         ev[STG_EX]   = 1'b1;
         code[STG_EX] = CC_OVF;
      end
      if (valid[STG_MEM] && data_fault) begin
         ev[STG_MEM]   = 1'b1;
         code[STG_MEM] = CC_DFAULT;
      end
   end

   // an interrupt slot never appears in the execute or memory stage (R7)
   always_comb begin
      assert (irq_slot[STG_EX] == 1'b0 && irq_slot[STG_MEM] == 1'b0)
         else $error("p_irq_slot_shallow_r7");
   end
endmodule

// File: rtl/trap_age_pick.sv
module trap_age_pick #(
   parameter int N  = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [N-1:0]  ev,
   output logic          any,
   output logic [IW-1:0] sel_idx,
   output logic [N-1:0]  sel_oh
);
   always_comb begin
      sel_idx = '0;
      // ascending scan: the deepest (oldest) set stage is written last
      for (int i = 0; i < N; i++) begin
         if (ev[i]) sel_idx = IW'(i);
      end
   end

   assign any    = |ev;
   assign sel_oh = any ? (N'(1) << sel_idx) : '0;

   p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel_oh));
   p_sel_oldest_r3: assert property (@(posedge clk) disable iff (!rst_n)
      any |-> ((ev >> sel_idx) == N'(1)));
endmodule

// File: rtl/trap_flush_gen.sv
module trap_flush_gen #(
   parameter int NT = 4,
   parameter int NS = 5
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NT-1:0] sel_oh,
   output logic [NS-1:0] flush
);
   genvar gi;
   generate
      for (gi = 0; gi < NS; gi++) begin : g_stage
         if (gi < NT) begin : g_trap
            // flushed when the offender is this stage or an older one
            assign flush[gi] = |sel_oh[NT-1:gi];
         end else begin : g_tail
            assign flush[gi] = 1'b0;
         end
      end
      for (gi = 0; gi < NS - 1; gi++) begin : g_chk
         p_flush_therm_r4: assert property (@(posedge clk) disable iff (!rst_n)
            flush[gi+1] |-> flush[gi]);
      end
   endgenerate
endmodule

// File: rtl/trap_irq_pend.sv
module trap_irq_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   input  logic take,
   output logic pend
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (pend_q & ~take) | req;
   end

   assign pend = pend_q;

   p_take_needs_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> pend_q);
   p_pend_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !take) |=> pend_q);
   p_pend_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !req) |=> !pend_q);
endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
   import trap_pkg::*;
#(
   parameter int          XLEN           = 32,
   parameter int          NSTG           = 5,
   parameter int          CAUSE_W        = 5,
   parameter logic [31:0] HANDLER_ADDR   = 32'h8000_0180,
   parameter bit          IRQ_AT_FETCH   = 1'b1,
   parameter bit          ONEHOT_EPC_MUX = 1'b1,
   localparam int         NT             = N_TRAP_STG,
   localparam int         IW             = $clog2(NT)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NT-1:0]      stg_valid,
   input  logic [NT*XLEN-1:0] stg_pc_flat,
   input  logic               fetch_fault,
   input  logic               undef_op,
   input  logic               alu_ovf,
   input  logic               data_fault,
   input  logic               dev_irq,
   input  logic               mem_we_in,
   output logic               cause_we,
   output logic [CAUSE_W-1:0] cause_val,
   output logic               epc_we,
   output logic [XLEN-1:0]    epc_val,
   output logic [NSTG-1:0]    flush_vec,
   output logic               pc_override,
   output logic [XLEN-1:0]    pc_target,
   output logic               mem_we_out
);
   generate
      if (NSTG < STG_WB + 1) begin : g_bad_nstg
         $error("NSTG must cover all five pipeline stages");
      end
      if (XLEN < 32) begin : g_bad_xlen
         $error("XLEN must hold the handler address");
      end
      if (CAUSE_W < CODE_W) begin : g_bad_cw
         $error("CAUSE_W too narrow for the cause codes");
      end
      if (HANDLER_ADDR[1:0] != 2'b00) begin : g_bad_vec
         $error("handler address must be word aligned");
      end
   endgenerate

   logic [XLEN-1:0]             pc_arr [NT];
   logic [NT-1:0]               ev, irq_slot, sel_oh;
   logic [NT-1:0][CODE_W-1:0]   code;
   logic [IW-1:0]               sel_idx;
   logic                        any, irq_pend, irq_take;
   logic [XLEN-1:0]             epc_sel;

   always_comb begin
      for (int i = 0; i < NT; i++) pc_arr[i] = stg_pc_flat[i*XLEN +: XLEN];
   end

   trap_irq_pend u_pend (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (dev_irq),
      .take (irq_take),
      .pend (irq_pend)
   );

   trap_src_map #(.NT(NT), .IRQ_AT_FETCH(IRQ_AT_FETCH)) u_src (
      .valid      (stg_valid),
      .fetch_fault(fetch_fault),
      .undef_op   (undef_op),
      .alu_ovf    (alu_ovf),
      .data_fault (data_fault),
      .irq_pend   (irq_pend),
      .ev         (ev),
      .irq_slot   (irq_slot),
      .code       (code)
   );

   trap_age_pick #(.N(NT)) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev),
      .any    (any),
      .sel_idx(sel_idx),
      .sel_oh (sel_oh)
   );

   trap_flush_gen #(.NT(NT), .NS(NSTG)) u_flush (
      .clk   (clk),
      .rst_n (rst_n),
      .sel_oh(sel_oh),
      .flush (flush_vec)
   );

   generate
      if (ONEHOT_EPC_MUX) begin : g_epc_andor
         always_comb begin
            epc_sel = '0;
            for (int i = 0; i < NT; i++) epc_sel |= {XLEN{sel_oh[i]}} & pc_arr[i];
         end
      end else begin : g_epc_index
         assign epc_sel = any ? pc_arr[sel_idx] : '0;
      end
   endgenerate

   assign irq_take    = |(sel_oh & irq_slot);
   assign cause_we    = any;
   assign epc_we      = any;
   assign cause_val   = any ? CAUSE_W'(code[sel_idx]) : '0;
   assign epc_val     = epc_sel;
   assign pc_override = any;
   assign pc_target   = any ? XLEN'(HANDLER_ADDR) : '0;
   assign mem_we_out  = mem_we_in & ~flush_vec[STG_MEM];

   p_commit_trio_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cause_we |-> (epc_we && pc_override && pc_target == XLEN'(HANDLER_ADDR)));
   p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !pc_override |-> (flush_vec == '0 && !cause_we));
   p_memwe_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_vec[STG_MEM] |-> !mem_we_out);
   p_invalid_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (stg_valid == '0) |-> !cause_we);
endmodule

// File: tb/trap_sequencer_tb.sv
module trap_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  stg_valid = '0;
   logic [31:0] pcs [4];
   logic [127:0] stg_pc_flat;
   logic fetch_fault = 0, undef_op = 0, alu_ovf = 0, data_fault = 0;
   logic dev_irq = 0, mem_we_in = 0;
   logic        cause_we, epc_we, pc_override, mem_we_out;
   logic [4:0]  cause_val, flush_vec;
   logic [31:0] epc_val, pc_target;
   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 4; i++) stg_pc_flat[i*32 +: 32] = pcs[i];
   end

   trap_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .stg_valid(stg_valid), .stg_pc_flat(stg_pc_flat),
      .fetch_fault(fetch_fault), .undef_op(undef_op), .alu_ovf(alu_ovf),
      .data_fault(data_fault), .dev_irq(dev_irq), .mem_we_in(mem_we_in),
      .cause_we(cause_we), .cause_val(cause_val), .epc_we(epc_we), .epc_val(epc_val),
      .flush_vec(flush_vec), .pc_override(pc_override), .pc_target(pc_target),
      .mem_we_out(mem_we_out)
   );

   localparam logic [31:0] HANDLER = 32'h8000_0180;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic idle();
      fetch_fault = 0; undef_op = 0; alu_ovf = 0; data_fault = 0;
      dev_irq = 0; mem_we_in = 0; stg_valid = 4'b1111;
   endtask

   // expected outputs of a taken event
   task automatic expect_take(input string req, input logic [4:0] cc,
                              input logic [31:0] pc, input logic [4:0] fl);
      chk({req, " cause_we"}, 32'(cause_we), 32'd1);
      chk({req, " epc_we"}, 32'(epc_we), 32'd1);
      chk({req, " cause"}, 32'(cause_val), 32'(cc));
      chk({req, " epc"}, epc_val, pc);
      chk({req, " flush"}, 32'(flush_vec), 32'(fl));
      chk({req, " R5 override"}, 32'(pc_override), 32'd1);
      chk({req, " R5 target"}, pc_target, HANDLER);
   endtask

   task automatic expect_none(input string req);
      chk({req, " cause_we"}, 32'(cause_we), 32'd0);
      chk({req, " epc_we"}, 32'(epc_we), 32'd0);
      chk({req, " flush"}, 32'(flush_vec), 32'd0);
      chk({req, " R5 override"}, 32'(pc_override), 32'd0);
      chk({req, " R5 target"}, pc_target, 32'd0);
   endtask

   task automatic t_reset();
      idle();
      repeat (3) @(negedge clk);
      #1 expect_none("R1 in reset");
      rst_n = 1'b1;
      @(negedge clk); #1 expect_none("R1 after reset");
   endtask

   task automatic t_single();
      @(negedge clk); idle(); fetch_fault = 1; #1 expect_take("R2 fetch", 5'd4, pcs[0], 5'b00001);
      @(negedge clk); idle(); undef_op = 1;    #1 expect_take("R2 undef", 5'd10, pcs[1], 5'b00011);
      @(negedge clk); idle(); alu_ovf = 1;     #1 expect_take("R2 ovf", 5'd12, pcs[2], 5'b00111);
      @(negedge clk); idle(); data_fault = 1;  #1 expect_take("R2 data", 5'd5, pcs[3], 5'b01111);
   endtask

   task automatic t_combo();
      @(negedge clk); idle();
      fetch_fault = 1; undef_op = 1; alu_ovf = 1; data_fault = 1;
      #1 expect_take("R3 all four", 5'd5, pcs[3], 5'b01111);
      @(negedge clk); idle(); fetch_fault = 1; alu_ovf = 1;
      #1 expect_take("R3 ovf over fetch", 5'd12, pcs[2], 5'b00111);
      @(negedge clk); idle(); fetch_fault = 1; undef_op = 1;
      #1 expect_take("R3 undef over fetch", 5'd10, pcs[1], 5'b00011);
   endtask

   task automatic t_invalid();
      @(negedge clk); idle(); stg_valid = 4'b0111; data_fault = 1; alu_ovf = 1;
      #1 expect_take("R6 mem bubble", 5'd12, pcs[2], 5'b00111);
      @(negedge clk); idle(); stg_valid = 4'b0000;
      fetch_fault = 1; undef_op = 1; alu_ovf = 1; data_fault = 1;
      #1 expect_none("R6 all bubbles");
   endtask

   task automatic t_memwe();
      @(negedge clk); idle(); mem_we_in = 1;
      #1 chk("R10 pass", 32'(mem_we_out), 32'd1);
      @(negedge clk); idle(); mem_we_in = 1; alu_ovf = 1;
      #1 chk("R10 younger fault", 32'(mem_we_out), 32'd1);
      @(negedge clk); idle(); mem_we_in = 1; data_fault = 1;
      #1 chk("R10 mem flushed", 32'(mem_we_out), 32'd0);
   endtask

   task automatic t_irq_basic();
      @(negedge clk); idle(); dev_irq = 1;
      #1 chk("R7 not yet", 32'(cause_we), 32'd0);
      @(negedge clk); idle();
      #1 expect_take("R7 taken at decode", 5'd0, pcs[1], 5'b00011);
      @(negedge clk); idle(); stg_valid = 4'b1100;
      #1 expect_none("R11 bubbles");
      @(negedge clk); idle();
      #1 expect_none("R11 not retaken");
   endtask

   task automatic t_irq_defer();
      @(negedge clk); idle(); dev_irq = 1;
      #1 chk("R8 pulse cycle", 32'(cause_we), 32'd0);
      @(negedge clk); idle(); alu_ovf = 1;
      #1 expect_take("R8 ovf first", 5'd12, pcs[2], 5'b00111);
      @(negedge clk); idle();
      #1 expect_take("R8 then request", 5'd0, pcs[1], 5'b00011);
      @(negedge clk); idle(); stg_valid = 4'b1100; dev_irq = 1;
      #1 expect_none("R8 empty front");
      @(negedge clk); idle(); stg_valid = 4'b1100;
      #1 expect_none("R8 still waiting");
      @(negedge clk); idle();
      #1 expect_take("R8 front refilled", 5'd0, pcs[1], 5'b00011);
   endtask

   task automatic t_irq_order();
      @(negedge clk); idle(); dev_irq = 1;
      #1 chk("R9 pulse cycle", 32'(cause_we), 32'd0);
      @(negedge clk); idle(); undef_op = 1;
      #1 expect_take("R9 request over undef", 5'd0, pcs[1], 5'b00011);
      @(negedge clk); idle(); undef_op = 1;
      #1 expect_take("R11 undef after", 5'd10, pcs[1], 5'b00011);
      @(negedge clk); idle(); stg_valid = 4'b1101; dev_irq = 1;
      #1 chk("R9 pulse cycle fetch", 32'(cause_we), 32'd0);
      @(negedge clk); idle(); stg_valid = 4'b1101; fetch_fault = 1;
      #1 expect_take("R9 request at fetch", 5'd0, pcs[0], 5'b00001);
   endtask

   initial begin
      pcs[0] = 32'h0000_1100; pcs[1] = 32'h0000_10FC;
      pcs[2] = 32'h0000_10F8; pcs[3] = 32'h0000_10F4;
      t_reset();
      t_single();
      t_combo();
      t_invalid();
      t_memwe();
      t_irq_basic();
      t_irq_defer();
      t_irq_order();
      @(negedge clk); idle();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule